// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps in-flight instructions in program order between issue and retirement in a dynamically scheduled core. Each issued instruction takes the entry at the tail of a circular buffer. The entry number goes back to the issue logic as the rename tag, which reservation stations use to name the result they wait for. Results arrive out of order on a shared broadcast bus. They are stored in the entry and are not written to the register file.

Retirement is strictly in order. On each cycle the oldest entry retires if its result has arrived. An ordinary instruction with a destination drives the architectural register write port. A branch retires without a write. If a branch result is flagged mispredicted, that branch retires in the same cycle and every younger entry is discarded, so none of them can change architectural state.

A query port answers the rename question for one register. It reports whether a buffered instruction is still going to write that register and, if so, the tag of the youngest such writer. It also reports whether that value has already arrived and what the value is. When the last pending writer of a register retires, the register stops being reported as pending.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ok` is 1, `alloc_tag` is 0, and `rf_we`, `retire`, `flush` and `qry_busy` are 0.
- R2: An accepted allocation (`alloc_req` and `alloc_ok` both 1) takes entry `alloc_tag`, and the next tag is the next index modulo DEPTH. `alloc_ok` is 0 while DEPTH entries are held or while `flush` is 1, and a request made then is ignored.
- R3: A result (`res_valid`, entry `res_tag`) marks that entry done and stores `res_value`. The oldest entry retires, one per cycle, in the cycle after it is both oldest and done. `retire` is 1 in that cycle.
- R4: A retiring entry allocated with `alloc_has_dst`=1 and `alloc_is_br`=0 drives `rf_we`=1, `rf_addr`=its destination and `rf_data`=its value. A retiring branch gives `rf_we`=0. This is the only way a register write happens.
- R5: A branch that retires with `res_mispred`=1 raises `flush` and gives no write. Every younger entry is discarded, the buffer becomes empty, and the next tag is the branch's index plus one.
- R6: The query for `qry_reg` reports `qry_busy`=1 and `qry_tag` equal to the youngest held entry with that destination. `qry_done` and `qry_value` report whether that entry's result has arrived and its value. Once no held entry writes the register, `qry_busy` is 0.
- R7: An allocation and a retirement in the same cycle both take effect.
- R8: `res_mispred` is ignored for an entry that is not a branch. Such an entry retires normally with its write and no flush.
- R9: A result addressed to an entry that is not held is ignored. The entry is still not done when it is later allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Issue wants an entry |
| alloc_is_br | input | 1 | Instruction being issued is a branch |
| alloc_has_dst | input | 1 | Instruction being issued writes a register |
| alloc_dst | input | $clog2(NREG) | Destination register of the instruction being issued |
| alloc_ok | output | 1 | An entry can be taken this cycle |
| alloc_tag | output | $clog2(DEPTH) | Entry number (rename tag) taken by an allocation |
| res_valid | input | 1 | Broadcast bus carries a result |
| res_tag | input | $clog2(DEPTH) | Entry the result belongs to |
| res_value | input | DW | Result value |
| res_mispred | input | 1 | Branch outcome disagreed with the prediction |
| qry_reg | input | $clog2(NREG) | Register being looked up |
| qry_busy | output | 1 | A held entry will write `qry_reg` |
| qry_tag | output | $clog2(DEPTH) | Youngest such entry |
| qry_done | output | 1 | That entry's result has arrived |
| qry_value | output | DW | That entry's result |
| rf_we | output | 1 | Architectural register write |
| rf_addr | output | $clog2(NREG) | Register written |
| rf_data | output | DW | Value written |
| retire | output | 1 | Oldest entry retires this cycle |
| flush | output | 1 | Retiring branch was mispredicted and younger entries are dropped |

## Verification
Two pairs of functions can meet in one cycle: allocation with retirement, and retirement with a flush that blocks allocation. The vector table keeps the buffer full while the oldest entry becomes ready, then issues in the cycle that entry retires. The next tag and the following retirement must show that both the allocation and the retirement took effect. A request made during the flush cycle must leave the tag at the branch's index plus one, and no squashed younger entry may appear on the register write port afterwards.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Index after idx on a ring of depth slots.
  function automatic int ring_next(input int idx, input int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  // Distance of idx from the oldest slot; larger means younger.
  function automatic int ring_age(input int idx, input int head, input int depth);
    return (idx >= head) ? (idx - head) : (idx + depth - head);
  endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  parameter int TW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_alloc,
  input  logic          do_retire,
  input  logic          do_flush,
  output logic [TW-1:0] head,
  output logic [TW-1:0] tail,
  output logic [CW-1:0] occ,
  output logic          full
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [TW-1:0] head_q, tail_q;
  logic [CW-1:0] occ_q;

  function automatic logic [TW-1:0] step(input logic [TW-1:0] p);
    return TW'(rob_pkg::ring_next(int'(p), DEPTH));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (do_retire) head_q <= step(head_q);
      if (do_flush) begin
        tail_q <= step(head_q);
        occ_q  <= '0;
      end else begin
        if (do_alloc) tail_q <= step(tail_q);
        occ_q <= occ_q + CW'(do_alloc) - CW'(do_retire);
      end
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign occ  = occ_q;
  assign full = (occ_q == FULL_CNT);
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
  parameter int DEPTH = 8,
  parameter int TW    = $clog2(DEPTH),
  parameter int RW    = 5,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_we,
  input  logic [TW-1:0]    alloc_idx,
  input  logic             alloc_br,
  input  logic             alloc_hasdst,
  input  logic [RW-1:0]    alloc_dst,
  input  logic             res_valid,
  input  logic [TW-1:0]    res_tag,
  input  logic [DW-1:0]    res_value,
  input  logic             res_mispred,
  input  logic             retire_we,
  input  logic [TW-1:0]    retire_idx,
  input  logic             flush,
  output logic [DEPTH-1:0] valid_o,
  output logic [DEPTH-1:0] done_o,
  output logic [DEPTH-1:0] br_o,
  output logic [DEPTH-1:0] mis_o,
  output logic [DEPTH-1:0] hasdst_o,
  output logic [RW-1:0]    dst_o [DEPTH],
  output logic [DW-1:0]    val_o [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic          v_q, d_q, b_q, m_q, h_q;
    logic [RW-1:0] dst_q;
    logic [DW-1:0] val_q;
    logic          hit_alloc, hit_res, hit_ret;

    assign hit_alloc = alloc_we && (alloc_idx == TW'(i));
    assign hit_res   = res_valid && (res_tag == TW'(i)) && v_q;
    assign hit_ret   = retire_we && (retire_idx == TW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        d_q   <= 1'b0;
        b_q   <= 1'b0;
        m_q   <= 1'b0;
        h_q   <= 1'b0;
        dst_q <= '0;
        val_q <= '0;
      end else if (flush) begin
        v_q <= 1'b0;
      end else begin
        if (hit_alloc) begin
          v_q   <= 1'b1;
          d_q   <= 1'b0;
          b_q   <= alloc_br;
          m_q   <= 1'b0;
          h_q   <= alloc_hasdst & ~alloc_br;
          dst_q <= alloc_dst;
        end else if (hit_res) begin
          d_q   <= 1'b1;
          val_q <= res_value;
          m_q   <= res_mispred & b_q;
        end
        if (hit_ret) v_q <= 1'b0;
      end
    end

    assign valid_o[i]  = v_q;
    assign done_o[i]   = d_q;
    assign br_o[i]     = b_q;
    assign mis_o[i]    = m_q;
    assign hasdst_o[i] = h_q;
    assign dst_o[i]    = dst_q;
    assign val_o[i]    = val_q;
  end
endmodule

// File: rtl/rob_tag_lookup.sv
module rob_tag_lookup #(
  parameter int DEPTH = 8,
  parameter int TW    = $clog2(DEPTH),
  parameter int RW    = 5,
  parameter int DW    = 32
) (
  input  logic [TW-1:0]    head,
  input  logic [DEPTH-1:0] valid_v,
  input  logic [DEPTH-1:0] done_v,
  input  logic [DEPTH-1:0] hasdst_v,
  input  logic [RW-1:0]    dst_a [DEPTH],
  input  logic [DW-1:0]    val_a [DEPTH],
  input  logic [RW-1:0]    qry_reg,
  output logic             busy,
  output logic [TW-1:0]    tag,
  output logic             done,
  output logic [DW-1:0]    value
);
  int best_age;

  always_comb begin
    busy     = 1'b0;
    tag      = '0;
    done     = 1'b0;
    value    = '0;
    best_age = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_v[i] && hasdst_v[i] && (dst_a[i] == qry_reg) &&
          (!busy || rob_pkg::ring_age(i, int'(head), DEPTH) > best_age)) begin
        busy     = 1'b1;
        best_age = rob_pkg::ring_age(i, int'(head), DEPTH);
        tag      = TW'(i);
        done     = done_v[i];
        value    = val_a[i];
      end
    end
  end
endmodule

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_req,
  input  logic                     alloc_is_br,
  input  logic                     alloc_has_dst,
  input  logic [$clog2(NREG)-1:0]  alloc_dst,
  output logic                     alloc_ok,
  output logic [$clog2(DEPTH)-1:0] alloc_tag,
  input  logic                     res_valid,
  input  logic [$clog2(DEPTH)-1:0] res_tag,
  input  logic [DW-1:0]            res_value,
  input  logic                     res_mispred,
  input  logic [$clog2(NREG)-1:0]  qry_reg,
  output logic                     qry_busy,
  output logic [$clog2(DEPTH)-1:0] qry_tag,
  output logic                     qry_done,
  output logic [DW-1:0]            qry_value,
  output logic                     rf_we,
  output logic [$clog2(NREG)-1:0]  rf_addr,
  output logic [DW-1:0]            rf_data,
  output logic                     retire,
  output logic                     flush
);
  localparam int TW = $clog2(DEPTH);
  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events
  logic          head_ready;
  logic          do_alloc;
  logic          do_retire;
  logic          do_flush;
  logic          full;
  logic [TW-1:0] head;
  logic [TW-1:0] tail;
  logic [CW-1:0] occ_q;

  logic [DEPTH-1:0] valid_v, done_v, br_v, mis_v, hasdst_v;
  logic [RW-1:0]    dst_a [DEPTH];
  logic [DW-1:0]    val_a [DEPTH];

  assign head_ready = valid_v[head] && done_v[head];
  assign do_retire  = head_ready;
  assign do_flush   = head_ready && br_v[head] && mis_v[head];
  assign alloc_ok   = !full && !do_flush;
  assign do_alloc   = alloc_req && alloc_ok;

  rob_ptr_ctrl #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_alloc  (do_alloc),
    .do_retire (do_retire),
    .do_flush  (do_flush),
    .head      (head),
    .tail      (tail),
    .occ       (occ_q),
    .full      (full)
  );

  rob_entry_array #(.DEPTH(DEPTH), .TW(TW), .RW(RW), .DW(DW)) u_ent (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_we     (do_alloc),
    .alloc_idx    (tail),
    .alloc_br     (alloc_is_br),
    .alloc_hasdst (alloc_has_dst),
    .alloc_dst    (alloc_dst),
    .res_valid    (res_valid),
    .res_tag      (res_tag),
    .res_value    (res_value),
    .res_mispred  (res_mispred),
    .retire_we    (do_retire),
    .retire_idx   (head),
    .flush        (do_flush),
    .valid_o      (valid_v),
    .done_o       (done_v),
    .br_o         (br_v),
    .mis_o        (mis_v),
    .hasdst_o     (hasdst_v),
    .dst_o        (dst_a),
    .val_o        (val_a)
  );

  rob_tag_lookup #(.DEPTH(DEPTH), .TW(TW), .RW(RW), .DW(DW)) u_look (
    .head     (head),
    .valid_v  (valid_v),
    .done_v   (done_v),
    .hasdst_v (hasdst_v),
    .dst_a    (dst_a),
    .val_a    (val_a),
    .qry_reg  (qry_reg),
    .busy     (qry_busy),
    .tag      (qry_tag),
    .done     (qry_done),
    .value    (qry_value)
  );

  assign alloc_tag = tail;
  assign retire    = do_retire;
  assign flush     = do_flush;
  assign rf_we     = do_retire && hasdst_v[head] && !do_flush;
  assign rf_addr   = dst_a[head];
  assign rf_data   = val_a[head];
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
  parameter int DEPTH = 8,
  parameter int TW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_req,
  input logic          alloc_ok,
  input logic [TW-1:0] alloc_tag,
  input logic          rf_we,
  input logic          retire,
  input logic          flush,
  input logic          qry_busy,
  input logic          qry_done,
  input logic [CW-1:0] occ
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [TW-1:0] LAST_IDX = TW'(DEPTH - 1);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_CNT);

  // R2
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL_CNT) |-> !alloc_ok);

  // R2
  tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_ok) |=>
      (alloc_tag == (($past(alloc_tag) == LAST_IDX) ? '0 : $past(alloc_tag) + 1'b1)));

  // R3
  write_needs_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> retire);

  // R5
  flush_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (retire && !rf_we && !alloc_ok));

  // R5
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0));

  // R6
  done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qry_done |-> qry_busy);
endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alloc_req (alloc_req),
  .alloc_ok  (alloc_ok),
  .alloc_tag (alloc_tag),
  .rf_we     (rf_we),
  .retire    (retire),
  .flush     (flush),
  .qry_busy  (qry_busy),
  .qry_done  (qry_done),
  .occ       (occ_q)
);

// File: tb/spec_rob_test.sv
module spec_rob_test;
  localparam int DEPTH = 4;
  localparam int NREG  = 8;
  localparam int DW    = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 1'b0, alloc_is_br = 1'b0, alloc_has_dst = 1'b0;
  logic [2:0]  alloc_dst = '0;
  logic        alloc_ok;
  logic [1:0]  alloc_tag;
  logic        res_valid = 1'b0;
  logic [1:0]  res_tag = '0;
  logic [15:0] res_value = '0;
  logic        res_mispred = 1'b0;
  logic [2:0]  qry_reg = '0;
  logic        qry_busy, qry_done;
  logic [1:0]  qry_tag;
  logic [15:0] qry_value;
  logic        rf_we;
  logic [2:0]  rf_addr;
  logic [15:0] rf_data;
  logic        retire, flush;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spec_rob #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_is_br(alloc_is_br), .alloc_has_dst(alloc_has_dst),
    .alloc_dst(alloc_dst), .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .res_mispred(res_mispred), .qry_reg(qry_reg), .qry_busy(qry_busy),
    .qry_tag(qry_tag), .qry_done(qry_done), .qry_value(qry_value),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .retire(retire), .flush(flush)
  );

  // Stimulus for one cycle and the outputs expected before it is applied.
  typedef struct packed {
    logic        req, br, hd;
    logic [2:0]  dst;
    logic        rv;
    logic [1:0]  rtag;
    logic [15:0] rval;
    logic        rmis;
    logic        eok;
    logic [1:0]  etag;
    logic        ewe;
    logic [2:0]  eaddr;
    logic [15:0] edata;
    logic        efl, eret;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    // 0-3: fill the buffer: r1, r2, branch, r1 (R2)
    '{1'b1,1'b0,1'b1,3'd1, 1'b0,2'd0,16'h0000,1'b0, 1'b1,2'd0,1'b0,3'd0,16'h0000,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,3'd2, 1'b0,2'd0,16'h0000,1'b0, 1'b1,2'd1,1'b0,3'd0,16'h0000,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,3'd0, 1'b0,2'd0,16'h0000,1'b0, 1'b1,2'd2,1'b0,3'd0,16'h0000,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,3'd1, 1'b0,2'd0,16'h0000,1'b0, 1'b1,2'd3,1'b0,3'd0,16'h0000,1'b0,1'b0},
    // 4: full, request to r7 ignored; entry 1 finishes early (R3)
    '{1'b1,1'b0,1'b1,3'd7, 1'b1,2'd1,16'h0022,1'b0, 1'b0,2'd0,1'b0,3'd0,16'h0000,1'b0,1'b0},
    // 5: oldest finishes
    '{1'b0,1'b0,1'b0,3'd0, 1'b1,2'd0,16'h0011,1'b0, 1'b0,2'd0,1'b0,3'd0,16'h0000,1'b0,1'b0},
    // 6: entry 0 retires while full; request still refused
    '{1'b1,1'b0,1'b1,3'd5, 1'b1,2'd3,16'h0033,1'b0, 1'b0,2'd0,1'b1,3'd1,16'h0011,1'b0,1'b1},
    // 7: allocate r5 in entry 0 while entry 1 retires (R7)
    '{1'b1,1'b0,1'b1,3'd5, 1'b0,2'd0,16'h0000,1'b0, 1'b1,2'd0,1'b1,3'd2,16'h0022,1'b0,1'b1},
    // 8: branch resolves correct
    '{1'b0,1'b0,1'b0,3'd0, 1'b1,2'd2,16'h0000,1'b0, 1'b1,2'd1,1'b0,3'd0,16'h0000,1'b0,1'b0},
    // 9: branch retires, no write (R4)
    '{1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,16'h0000,1'b0, 1'b1,2'd1,1'b0,3'd0,16'h0000,1'b0,1'b1},
    // 10: r1 retires with 0x33; allocate a branch in entry 1
    '{1'b1,1'b1,1'b0,3'd0, 1'b0,2'd0,16'h0000,1'b0, 1'b1,2'd1,1'b1,3'd1,16'h0033,1'b0,1'b1},
    // 11: allocate r6 in entry 2; branch resolves mispredicted
    '{1'b1,1'b0,1'b1,3'd6, 1'b1,2'd1,16'h0000,1'b1, 1'b1,2'd2,1'b0,3'd0,16'h0000,1'b0,1'b0},
    // 12: r5 finishes
    '{1'b0,1'b0,1'b0,3'd0, 1'b1,2'd0,16'h0055,1'b0, 1'b1,2'd3,1'b0,3'd0,16'h0000,1'b0,1'b0},
    // 13: r5 retires; squash victim r6 finishes
    '{1'b0,1'b0,1'b0,3'd0, 1'b1,2'd2,16'h0066,1'b0, 1'b1,2'd3,1'b1,3'd5,16'h0055,1'b0,1'b1},
    // 14: mispredicted branch retires, flush, request refused (R5)
    '{1'b1,1'b0,1'b1,3'd3, 1'b0,2'd0,16'h0000,1'b0, 1'b0,2'd3,1'b0,3'd0,16'h0000,1'b1,1'b1},
    // 15-16: empty, tag after branch, r6 never written (R5)
    '{1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,16'h0000,1'b0, 1'b1,2'd2,1'b0,3'd0,16'h0000,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,16'h0000,1'b0, 1'b1,2'd2,1'b0,3'd0,16'h0000,1'b0,1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_req = 1'b0; alloc_is_br = 1'b0; alloc_has_dst = 1'b0; alloc_dst = '0;
    res_valid = 1'b0; res_tag = '0; res_value = '0; res_mispred = 1'b0;
  endtask

  task automatic cycle();
    @(negedge clk);
    idle_inputs();
    #1;
  endtask

  task automatic do_alloc(input logic [2:0] d);
    alloc_req = 1'b1; alloc_has_dst = 1'b1; alloc_dst = d;
    cycle();
  endtask

  task automatic do_result(input logic [1:0] t, input logic [15:0] v, input logic m);
    res_valid = 1'b1; res_tag = t; res_value = v; res_mispred = m;
    cycle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(alloc_ok && alloc_tag == 2'd0, "R1", "alloc_ok/tag", {alloc_ok, alloc_tag}, 3'b100);
    check(!rf_we && !retire && !flush && !qry_busy, "R1", "we/retire/flush/busy",
          {rf_we, retire, flush, qry_busy}, 4'b0000);

    for (int k = 0; k < NV; k++) begin
      check(alloc_ok == TBL[k].eok && alloc_tag == TBL[k].etag, "R2 R7",
            $sformatf("vector %0d alloc ok/tag", k), {alloc_ok, alloc_tag}, {TBL[k].eok, TBL[k].etag});
      check(rf_we == TBL[k].ewe && (!TBL[k].ewe || (rf_addr == TBL[k].eaddr && rf_data == TBL[k].edata)),
            "R3 R4", $sformatf("vector %0d write we/addr/data", k),
            {rf_we, rf_addr, rf_data}, {TBL[k].ewe, TBL[k].eaddr, TBL[k].edata});
      check(retire == TBL[k].eret, "R3", $sformatf("vector %0d retire", k), retire, TBL[k].eret);
      check(flush == TBL[k].efl, "R5", $sformatf("vector %0d flush", k), flush, TBL[k].efl);
      alloc_req = TBL[k].req; alloc_is_br = TBL[k].br; alloc_has_dst = TBL[k].hd;
      alloc_dst = TBL[k].dst; res_valid = TBL[k].rv; res_tag = TBL[k].rtag;
      res_value = TBL[k].rval; res_mispred = TBL[k].rmis;
      cycle();
    end

    // Buffer empty, oldest slot 2.
    qry_reg = 3'd1; #1;
    check(!qry_busy, "R6", "r1 cleared after retire", qry_busy, 0);
    qry_reg = 3'd6; #1;
    check(!qry_busy, "R5", "squashed r6 not pending", qry_busy, 0);

    do_alloc(3'd4);                    // entry 2
    qry_reg = 3'd4; #1;
    check(qry_busy && qry_tag == 2'd2 && !qry_done, "R6", "r4 producer",
          {qry_busy, qry_tag, qry_done}, 4'b1100);
    do_alloc(3'd4);                    // entry 3
    #1;
    check(qry_busy && qry_tag == 2'd3 && !qry_done, "R6", "youngest r4 producer",
          {qry_busy, qry_tag, qry_done}, 4'b1110);
    do_result(2'd3, 16'h0077, 1'b0);
    check(qry_done && qry_value == 16'h0077 && qry_tag == 2'd3, "R6", "forwarded value",
          {qry_done, qry_tag, qry_value}, {1'b1, 2'd3, 16'h0077});
    do_result(2'd0, 16'h0099, 1'b0);   // entry 0 not held
    check(!rf_we && !retire, "R9", "stray result no retire", {rf_we, retire}, 0);
    do_result(2'd2, 16'h0044, 1'b1);   // mispredict flag on non-branch
    check(rf_we && rf_addr == 3'd4 && rf_data == 16'h0044 && !flush, "R8", "non-branch retires",
          {flush, rf_we, rf_addr, rf_data}, {1'b0, 1'b1, 3'd4, 16'h0044});
    cycle();
    check(rf_we && rf_data == 16'h0077 && !flush, "R8", "younger entry survives",
          {flush, rf_we, rf_data}, {1'b0, 1'b1, 16'h0077});
    cycle();
    check(!qry_busy && !rf_we && alloc_ok && alloc_tag == 2'd0, "R6", "r4 cleared, buffer empty",
          {qry_busy, rf_we, alloc_ok, alloc_tag}, 5'b00100);
    do_alloc(3'd2);                    // entry 0
    qry_reg = 3'd2; #1;
    check(qry_busy && qry_tag == 2'd0 && !qry_done, "R9", "reused entry not done",
          {qry_busy, qry_tag, qry_done}, 4'b1000);
    cycle();
    check(!rf_we && !retire, "R9", "reused entry does not retire", {rf_we, retire}, 0);

    finish_run();
  end
endmodule